// File: doc/BRIEF.md
# MDIO Management Serial Slave

This block is the serial management slave for one channel of a multi-channel PHY. It runs on the management clock and samples the data line on each rising edge. A frame is accepted only after the line has been held high for at least 32 clocks. The frame then starts with a low bit followed by a high bit. After that come a 2-bit opcode, a 5-bit PHY address, a 5-bit register address and two turnaround bits, all sent MSB first. Sixteen data bits follow.

The slave compares the PHY address in the frame against its own. Bits [4:2] of its own address come from three strap pins, and bits [1:0] equal the `CHANNEL` parameter. On a matching read, it fetches the addressed register through a combinational read port and shifts the value out on the data line through an output enable. On a matching write, it assembles the 16 data bits and emits a one-cycle write strobe to the register file.

Each completed frame, and each aborted or ignored one, forces the slave back to hunting for a fresh idle period.

Top module: `mdio_slave`

## Requirements
- R1: After reset, `mdio_oe` and `reg_wr_en` are low, and the idle counter starts from zero, so 32 ones must follow reset before a frame is accepted.
- R2: Idle is reached only after at least 32 consecutive ones are sampled outside a frame. Any 0 sampled outside a frame clears the count. A frame preceded by 31 ones is ignored, and one preceded by more than 32 ones is accepted.
- R3: From idle, a sampled 0 followed by a sampled 1 starts a frame. A 0 followed by another 0 abandons the start, and a fresh idle is then needed.
- R4: After the start bits, the header fields arrive MSB first in this order: opcode (2 bits), PHY address (5 bits), register address (5 bits), turnaround (2 bits). The 16 data bits then follow MSB first. The slave drives nothing during the header except as stated in R6.
- R5: The frame's PHY address must equal {`phy_strap`[2:0], `CHANNEL`[1:0]}. With any other address, the frame causes no drive and no write.
- R6: On a matching read (opcode 2'b10), `mdio_oe` rises after the edge that samples the first turnaround bit, with `mdio_o` = 0. After each following rising edge, `mdio_o` presents the next register bit, MSB first. `mdio_oe` falls after the edge that samples the last data bit, so it is high for exactly 17 cycles.
- R7: On a matching write (opcode 2'b01), `reg_wr_en` pulses high for exactly one cycle, directly after the edge that samples the last data bit. During that pulse it carries the register address on `reg_wr_addr` and the 16 data bits on `reg_wr_data`. `mdio_oe` stays low for the whole write.
- R8: Opcodes 2'b00 and 2'b11 cause no drive and no write.
- R9: After any frame that started, whether or not it was acted on, a new frame is accepted only after another 32 consecutive ones.
- R10: On a matching read, `reg_rd_addr` holds the frame's register address in the cycle after the edge that samples the first turnaround bit. The read data is taken at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all sampling is on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Data value driven during reads |
| mdio_oe | output | 1 | Output enable for the data line |
| phy_strap | input | 3 | Upper three bits of the PHY address |
| reg_rd_addr | output | 5 | Register address for the read port |
| reg_rd_data | input | 16 | Read data returned combinationally by the register file |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_addr | output | 5 | Register address for the write |
| reg_wr_data | output | 16 | Data for the write |

## Verification
All 32 register addresses are written with address-dependent values and then read back. This separates a wrong bit order, a wrong turnaround position and an off-by-one in the drive window. The PHY address is swept over all 32 values, so only the value built from the straps and the channel number should respond. The invalid opcodes are tried with a valid address. The idle rule is probed with several patterns: 31 ones, 40 ones, no ones straight after a frame, and an abandoned start (0,0). These separate a counter that is too short or that fails to clear from a correct one.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;

    typedef enum logic [1:0] {
        FR_HUNT  = 2'd0,
        FR_START = 2'd1,
        FR_HDR   = 2'd2,
        FR_DATA  = 2'd3
    } fr_state_e;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;

endpackage

// File: rtl/mdio_idle_det.sv
module mdio_idle_det #(
    parameter int PRE_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    input  logic busy_i,
    output logic idle_o
);
    localparam int CW = $clog2(PRE_LEN + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (busy_i || !bit_i) begin
            cnt_d = '0;
        end else if (cnt_q != CW'(PRE_LEN)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign idle_o = (cnt_q == CW'(PRE_LEN));
endmodule

// File: rtl/mdio_frame_ctl.sv
module mdio_frame_ctl
    import mdio_slave_pkg::*;
#(
    parameter int CHANNEL = 0,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_i,
    input  logic              idle_i,
    input  logic [ADDR_W-3:0] strap_i,
    output logic              busy_o,
    output logic              arm_o,
    output logic              load_o,
    output logic              shift_o,
    output logic              stop_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] wr_data_o
);
    localparam int HDR_W    = 2 + 2 * ADDR_W;
    localparam int HDR_BITS = HDR_W + 2;
    localparam int CNT_W    = $clog2(DATA_W);

    typedef struct packed {
        fr_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [HDR_W-1:0]  hdr;
        logic [DATA_W-2:0] wsh;
        logic [ADDR_W-1:0] ra;
        logic              wr_hit;
        logic              wr_en;
        logic [DATA_W-1:0] wr_data;
    } fr_regs_t;

    fr_regs_t s_d, s_q;

    logic [1:0]        op_w;
    logic [ADDR_W-1:0] phy_w;
    logic [ADDR_W-1:0] own_addr;
    logic              addr_hit;
    logic              at_arm;

    assign op_w     = s_q.hdr[HDR_W-1 -: 2];
    assign phy_w    = s_q.hdr[2*ADDR_W-1 -: ADDR_W];
    assign own_addr = {strap_i, 2'(CHANNEL)};
    assign addr_hit = (phy_w == own_addr);
    assign at_arm   = (s_q.st == FR_HDR) && (s_q.cnt == CNT_W'(HDR_W));

    always_comb begin
        s_d       = s_q;
        s_d.wr_en = 1'b0;
        unique case (s_q.st)
            FR_HUNT: begin
                if (idle_i && !bit_i) s_d.st = FR_START;
            end
            FR_START: begin
                s_d.cnt = '0;
                s_d.st  = bit_i ? FR_HDR : FR_HUNT;
            end
            FR_HDR: begin
                s_d.hdr = {s_q.hdr[HDR_W-2:0], bit_i};
                if (at_arm) begin
                    s_d.ra     = s_q.hdr[ADDR_W-1:0];
                    s_d.wr_hit = addr_hit && (op_w == OPC_WRITE);
                end
                if (s_q.cnt == CNT_W'(HDR_BITS - 1)) begin
                    s_d.st  = FR_DATA;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            FR_DATA: begin
                s_d.wsh = {s_q.wsh[DATA_W-3:0], bit_i};
                if (s_q.cnt == CNT_W'(DATA_W - 1)) begin
                    s_d.st  = FR_HUNT;
                    s_d.cnt = '0;
                    if (s_q.wr_hit) begin
                        s_d.wr_en   = 1'b1;
                        s_d.wr_data = {s_q.wsh, bit_i};
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.st = FR_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= FR_HUNT;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o     = (s_q.st != FR_HUNT);
    assign arm_o      = at_arm && addr_hit && (op_w == OPC_READ);
    assign load_o     = (s_q.st == FR_HDR) && (s_q.cnt == CNT_W'(HDR_BITS - 1));
    assign shift_o    = (s_q.st == FR_DATA) && (s_q.cnt != CNT_W'(DATA_W - 1));
    assign stop_o     = (s_q.st == FR_DATA) && (s_q.cnt == CNT_W'(DATA_W - 1));
    assign reg_addr_o = s_q.ra;
    assign wr_en_o    = s_q.wr_en;
    assign wr_data_o  = s_q.wr_data;
endmodule

// File: rtl/mdio_tx.sv
module mdio_tx #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic              stop_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              out_o,
    output logic              oe_o
);
    typedef struct packed {
        logic              oe;
        logic              out;
        logic [DATA_W-1:0] sh;
    } tx_regs_t;

    tx_regs_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (arm_i) begin
            t_d.oe  = 1'b1;
            t_d.out = 1'b0;
        end else if (stop_i) begin
            t_d.oe  = 1'b0;
            t_d.out = 1'b0;
        end else if (t_q.oe && load_i) begin
            t_d.out = rd_data_i[DATA_W-1];
            t_d.sh  = {rd_data_i[DATA_W-2:0], 1'b0};
        end else if (t_q.oe && shift_i) begin
            t_d.out = t_q.sh[DATA_W-1];
            t_d.sh  = {t_q.sh[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign out_o = t_q.out;
    assign oe_o  = t_q.oe;
endmodule

// File: rtl/mdio_slave.sv
module mdio_slave #(
    parameter int CHANNEL = 0,
    parameter int PRE_LEN = 32,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic [2:0]        phy_strap,
    output logic [ADDR_W-1:0] reg_rd_addr,
    input  logic [DATA_W-1:0] reg_rd_data,
    output logic              reg_wr_en,
    output logic [ADDR_W-1:0] reg_wr_addr,
    output logic [DATA_W-1:0] reg_wr_data
);
    logic idle_w, busy_w, arm_w, load_w, shift_w, stop_w;
    logic [ADDR_W-1:0] ra_w;

    mdio_idle_det #(.PRE_LEN(PRE_LEN)) u_idle (
        .clk    (mdc),
        .rst_n  (rst_n),
        .bit_i  (mdio_i),
        .busy_i (busy_w),
        .idle_o (idle_w)
    );

    mdio_frame_ctl #(.CHANNEL(CHANNEL), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
        .clk        (mdc),
        .rst_n      (rst_n),
        .bit_i      (mdio_i),
        .idle_i     (idle_w),
        .strap_i    (phy_strap),
        .busy_o     (busy_w),
        .arm_o      (arm_w),
        .load_o     (load_w),
        .shift_o    (shift_w),
        .stop_o     (stop_w),
        .reg_addr_o (ra_w),
        .wr_en_o    (reg_wr_en),
        .wr_data_o  (reg_wr_data)
    );

    mdio_tx #(.DATA_W(DATA_W)) u_tx (
        .clk       (mdc),
        .rst_n     (rst_n),
        .arm_i     (arm_w),
        .load_i    (load_w),
        .shift_i   (shift_w),
        .stop_i    (stop_w),
        .rd_data_i (reg_rd_data),
        .out_o     (mdio_o),
        .oe_o      (mdio_oe)
    );

    assign reg_rd_addr = ra_w;
    assign reg_wr_addr = ra_w;
endmodule

// File: rtl/mdio_slave_chk.sv
module mdio_slave_chk (
    input logic mdc,
    input logic rst_n,
    input logic mdio_o,
    input logic mdio_oe,
    input logic reg_wr_en
);
    logic [4:0] oe_len_q;
    logic [6:0] wr_gap_q;

    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) begin
            oe_len_q <= '0;
            wr_gap_q <= '0;
        end else begin
            oe_len_q <= mdio_oe ? ((oe_len_q == 5'd31) ? oe_len_q : oe_len_q + 1'b1) : 5'd0;
            wr_gap_q <= reg_wr_en ? 7'd0 : ((wr_gap_q == 7'd127) ? wr_gap_q : wr_gap_q + 1'b1);
        end
    end

    // R6: turnaround bit driven low
    p_ta_low_r6: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o);

    // R6: drive window is 17 cycles long
    p_drive_len_r6: assert property (@(posedge mdc) disable iff (!rst_n)
        $fell(mdio_oe) |-> (oe_len_q == 5'd17));

    // R7: strobe lasts one cycle
    p_wr_pulse_r7: assert property (@(posedge mdc) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    // R7: never driving during a write strobe
    p_no_clash_r7: assert property (@(posedge mdc) disable iff (!rst_n)
        reg_wr_en |-> !mdio_oe);

    // R9: consecutive writes need a fresh idle plus a full frame
    p_wr_gap_r9: assert property (@(posedge mdc) disable iff (!rst_n)
        reg_wr_en |-> (wr_gap_q >= 7'd62));
endmodule

bind mdio_slave mdio_slave_chk u_chk (
    .mdc       (mdc),
    .rst_n     (rst_n),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .reg_wr_en (reg_wr_en)
);

// File: tb/sim_mdio_slave.sv
module sim_mdio_slave;
    localparam int CLK_PERIOD = 10;
    localparam int CHAN = 2;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [4:0] OWN = {STRAP, 2'(CHAN)};

    logic mdc = 1'b0;
    logic rst_n = 1'b0;
    logic drv_bit = 1'b0;
    logic mdio_i, mdio_o, mdio_oe, reg_wr_en;
    logic [4:0] reg_rd_addr, reg_wr_addr;
    logic [15:0] reg_rd_data, reg_wr_data;
    logic [15:0] file_mem [32];
    logic [15:0] exp_mem [32];
    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) mdc = ~mdc;

    assign mdio_i = mdio_oe ? mdio_o : drv_bit;
    assign reg_rd_data = file_mem[reg_rd_addr];

    always @(posedge mdc) if (reg_wr_en) file_mem[reg_wr_addr] <= reg_wr_data;

    mdio_slave #(.CHANNEL(CHAN)) u0 (
        .mdc(mdc), .rst_n(rst_n), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .phy_strap(STRAP), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic send_bits(input int n, input logic b);
        for (int k = 0; k < n; k++) begin
            @(negedge mdc);
            drv_bit = b;
        end
    endtask

    task automatic run_frame(input int pre, input logic [1:0] op, input logic [4:0] phy,
                             input logic [4:0] ra, input logic [15:0] wd,
                             input bit exp_rd, input bit exp_wr, input string req);
        logic [31:0] fb;
        logic [15:0] ed;
        bit drv_ok = 1'b1;
        bit wr_seen = 1'b0;
        logic [31:0] bad_act = '0;
        logic [31:0] bad_exp = '0;
        logic [4:0] seen_ra = '0;
        ed = exp_mem[ra];
        fb = {2'b01, op, phy, ra, 2'b10, wd};
        send_bits(pre, 1'b1);
        for (int i = 0; i < 33; i++) begin
            logic e_oe, e_o;
            @(negedge mdc);
            e_oe = exp_rd && (i >= 15) && (i < 32);
            e_o  = (exp_rd && i >= 16 && i < 32) ? ed[31-i] : 1'b0;
            if (drv_ok && ((mdio_oe !== e_oe) || (e_oe && mdio_o !== e_o))) begin
                drv_ok  = 1'b0;
                bad_act = {16'(i), 14'd0, mdio_oe, mdio_o};
                bad_exp = {16'(i), 14'd0, e_oe, e_o};
            end
            if (i < 32) begin
                if (reg_wr_en) wr_seen = 1'b1;
                if (i == 15) seen_ra = reg_rd_addr;
                drv_bit = fb[31-i];
            end
        end
        check(drv_ok, {req, " drive"}, bad_act, bad_exp);
        if (exp_rd) check(seen_ra == ra, "R10 read address", 32'(seen_ra), 32'(ra));
        check(!wr_seen && (reg_wr_en == exp_wr) &&
              (!exp_wr || (reg_wr_addr == ra && reg_wr_data == wd)),
              {req, " write"}, {reg_wr_en, 10'd0, reg_wr_addr, reg_wr_data},
              {exp_wr, 10'd0, ra, wd});
        if (exp_wr) exp_mem[ra] = wd;
        drv_bit = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: act=running exp=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int a = 0; a < 32; a++) begin
            file_mem[a] = '0;
            exp_mem[a]  = '0;
        end
        repeat (3) @(negedge mdc);
        // R1: reset state
        check(!mdio_oe && !reg_wr_en, "R1 reset outputs", {mdio_oe, reg_wr_en}, 0);
        @(negedge mdc);
        rst_n = 1'b1;
        // R1 / R2: only 31 ones after reset
        run_frame(31, 2'b01, OWN, 5'd3, 16'h1234, 0, 0, "R1 short preamble after reset");
        // R7 / R4: single write, and 40 ones accepted (R2)
        run_frame(40, 2'b01, OWN, 5'd3, 16'h1234, 0, 1, "R2 long preamble write");
        run_frame(32, 2'b10, OWN, 5'd3, 16'h0, 1, 0, "R6 first read");
        // R7: sweep writes
        for (int a = 0; a < 32; a++)
            run_frame(32, 2'b01, OWN, 5'(a), 16'(16'hA5C3 ^ (a * 16'h1111) ^ (a << 11)), 0, 1, "R7 write sweep");
        // R6 / R4: sweep reads
        for (int a = 0; a < 32; a++)
            run_frame(32, 2'b10, OWN, 5'(a), 16'h0, 1, 0, "R6 read sweep");
        // R8: invalid opcodes
        run_frame(32, 2'b00, OWN, 5'd7, 16'hFFFF, 0, 0, "R8 opcode 00");
        run_frame(32, 2'b11, OWN, 5'd7, 16'h0F0F, 0, 0, "R8 opcode 11");
        run_frame(32, 2'b10, OWN, 5'd7, 16'h0, 1, 0, "R8 register unchanged");
        // R5: address sweep for reads, and one mismatching write
        for (int p = 0; p < 32; p++)
            run_frame(32, 2'b10, 5'(p), 5'd5, 16'h0, (5'(p) == OWN), 0, "R5 address sweep");
        run_frame(32, 2'b01, OWN ^ 5'b00001, 5'd5, 16'hDEAD, 0, 0, "R5 foreign write");
        run_frame(32, 2'b10, OWN, 5'd5, 16'h0, 1, 0, "R5 register unchanged");
        // R9: back-to-back frame without idle
        run_frame(32, 2'b01, OWN, 5'd9, 16'h5AA5, 0, 1, "R9 first frame");
        run_frame(0, 2'b01, OWN, 5'd9, 16'h1111, 0, 0, "R9 no idle between frames");
        run_frame(32, 2'b01, OWN, 5'd9, 16'h2222, 0, 1, "R9 idle restored");
        // R2: 31 ones after a frame
        run_frame(31, 2'b10, OWN, 5'd9, 16'h0, 0, 0, "R2 31 ones rejected");
        // R3: abandoned start (0 then 0)
        send_bits(32, 1'b1);
        send_bits(1, 1'b0);
        run_frame(0, 2'b01, OWN, 5'd9, 16'h3333, 0, 0, "R3 abandoned start");
        run_frame(32, 2'b10, OWN, 5'd9, 16'h0, 1, 0, "R3 valid start after abandon");
        send_bits(4, 1'b1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule